// File: doc/BRIEF.md
# Multi-Hybrid Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It combines three component predictors, each good at a different kind of branch. A small per-PC bimodal table learns strongly biased branches quickly. A gshare table with a short global history learns short repeating patterns after only a few visits. A gshare table with a long history captures long-range correlation, but it needs much more training before its answers are useful.

A table of selection counters decides which component to trust. It holds one 2-bit counter per component for each entry and is indexed from the branch PC. The component whose counter is highest supplies the final answer. While the long-history table is still training, a faster component that is proving more accurate therefore wins the vote.

The fetch stage presents a PC and gets, in the same cycle, the final direction, the chosen component and every component's own guess. When the branch resolves, the back end returns the PC, the real outcome and the component guesses it captured. The update is written at the next clock edge.

Top module: `mhbp_top`

## Requirements
- R1: After reset, every component counter is weakly not-taken (value 1), every selection counter is 0 and the global history is all zeros. Any PC then predicts not-taken from all three components, and component 2 is chosen.
- R2: Component 0 is a 2-bit saturating counter per PC. It is indexed by PC bits [7:2], and its direction is the counter's upper bit. A taken update increments the counter up to a limit of 3, and a not-taken update decrements it down to a limit of 0.
- R3: Component 1 is a table of 2-bit saturating counters. Its index is PC bits [7:2] XOR the four most recent outcomes, placed in index bits [3:0].
- R4: Component 2 is a table of 2-bit saturating counters. Its index is PC bits [11:2] XOR history bits [9:0], further XORed with history bits [11:10] placed in index bits [1:0].
- R5: Each valid update shifts its real outcome into bit 0 of a 12-bit global history; older outcomes move up one place. An update writes the component tables at indices computed with the history as it stood before that shift.
- R6: On an update, the selection counter of every component whose returned guess matched the outcome rises by one, up to a limit of 3. The selection table has 64 entries, indexed by PC bits [7:2].
- R7: On an update, the counters of the components whose guess was wrong fall by one, down to a limit of 0. This happens only if none of the correct components had a counter of 3 before the update.
- R8: The chosen component is the one with the highest selection counter. Ties go to component 2 first, then component 1, then component 0. The final direction equals the chosen component's guess, and the chosen component number is never 3.
- R9: Prediction outputs are combinational from the PC and the current state. An update changes state only at the clock edge on which the valid input is high, so a prediction made in the same cycle still sees the old state. While the valid input is low, the update inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_pc | input | PC_W (32) | PC of the branch being predicted |
| pred_taken | output | 1 | Final predicted direction (1 = taken) |
| pred_comp | output | 2 | Component chosen: 0 bimodal, 1 short gshare, 2 long gshare |
| pred_comp_dir | output | 3 | Each component's own guess, bit n for component n |
| upd_valid | input | 1 | Update strobe |
| upd_pc | input | PC_W (32) | PC of the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch |
| upd_comp_dir | input | 3 | Component guesses captured at prediction time |

## Verification
A strongly biased branch run past saturation in both directions separates the bimodal counter limits from the history-indexed tables. A strictly alternating branch and a taken-taken-taken-not loop can only be learned through the history hashes. They expose index, fold or shift-order errors in the short and long tables, and they move the selectors between components. Two PCs that share a selector entry but disagree in outcome drive the selection counters through saturation, the hold-off on decrements and tie cases. Held-off updates and a same-cycle predict/update pair show that state moves only on a valid edge.

// File: rtl/mhbp_pkg.sv
package mhbp_pkg;

    localparam int NCOMP = 3;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_WEAK_NT = 2'b01;
    localparam ctr2_t CTR_TOP     = 2'b11;
    localparam ctr2_t CTR_BOTTOM  = 2'b00;
    localparam ctr2_t SEL_INIT    = 2'b00;

    typedef enum logic [1:0] {
        COMP_BIMODAL = 2'd0,
        COMP_SHORT   = 2'd1,
        COMP_LONG    = 2'd2
    } comp_e;

    function automatic ctr2_t ctr_up(input ctr2_t c);
        return (c == CTR_TOP) ? c : c + 2'd1;
    endfunction

    function automatic ctr2_t ctr_down(input ctr2_t c);
        return (c == CTR_BOTTOM) ? c : c - 2'd1;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mhbp_pht.sv
module mhbp_pht
    import mhbp_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int HIST_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HIST_W-1:0] hist,
    input  logic [IDX_W-1:0]  rd_base,
    output logic              rd_taken,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_base,
    input  logic              wr_taken
);

    localparam int ENT = 1 << IDX_W;

    typedef struct packed {
        logic [ENT-1:0][1:0] cnt;
    } pht_st_t;

    localparam pht_st_t RESET_ST = '{cnt: {ENT{CTR_WEAK_NT}}};

    pht_st_t st_d, st_q;

    // history folded onto the index bits, wrapping every IDX_W positions
    function automatic logic [IDX_W-1:0] hash(input logic [IDX_W-1:0] base,
                                              input logic [HIST_W-1:0] h);
        logic [IDX_W-1:0] r;
        r = base;
        for (int i = 0; i < HIST_W; i++) begin
            r[i % IDX_W] = r[i % IDX_W] ^ h[i];
        end
        return r;
    endfunction

    logic [IDX_W-1:0] rd_idx, wr_idx;

    assign rd_idx   = hash(rd_base, hist);
    assign wr_idx   = hash(wr_base, hist);
    assign rd_taken = st_q.cnt[rd_idx][1];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.cnt[wr_idx] = wr_taken ? ctr_up(st_q.cnt[wr_idx])
                                        : ctr_down(st_q.cnt[wr_idx]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/mhbp_sel.sv
module mhbp_sel
    import mhbp_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [NCOMP-1:0] comp_dir,
    output logic             pred_taken,
    output logic [1:0]       pred_comp,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken,
    input  logic [NCOMP-1:0] wr_comp_dir
);

    localparam int ENT = 1 << IDX_W;

    typedef struct packed {
        logic [ENT-1:0][NCOMP-1:0][1:0] sel;
    } sel_st_t;

    localparam sel_st_t RESET_ST = '{sel: {(ENT*NCOMP){SEL_INIT}}};

    sel_st_t st_d, st_q;

    logic [1:0] best_c;
    ctr2_t      best_v;

    // scan upward with >= so a later (longer-history) component wins ties
    always_comb begin
        best_c = 2'd0;
        best_v = st_q.sel[rd_idx][0];
        for (int c = 1; c < NCOMP; c++) begin
            if (st_q.sel[rd_idx][c] >= best_v) begin
                best_c = 2'(c);
                best_v = st_q.sel[rd_idx][c];
            end
        end
    end

    assign pred_comp  = best_c;
    assign pred_taken = comp_dir[best_c];

    logic [NCOMP-1:0] right, at_top;
    logic             hold_wrong;

    always_comb begin
        for (int c = 0; c < NCOMP; c++) begin
            right[c]  = (wr_comp_dir[c] == wr_taken);
            at_top[c] = (st_q.sel[wr_idx][c] == CTR_TOP);
        end
        hold_wrong = |(right & at_top);
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int c = 0; c < NCOMP; c++) begin
                if (right[c])
                    st_d.sel[wr_idx][c] = ctr_up(st_q.sel[wr_idx][c]);
                else if (!hold_wrong)
                    st_d.sel[wr_idx][c] = ctr_down(st_q.sel[wr_idx][c]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/mhbp_top.sv
module mhbp_top
    import mhbp_pkg::*;
#(
    parameter int PC_W        = 32,
    parameter int BIM_IDX_W   = 6,
    parameter int SHORT_IDX_W = 6,
    parameter int LONG_IDX_W  = 10,
    parameter int SHORT_HIST  = 4,
    parameter int LONG_HIST   = 12,
    parameter int SEL_IDX_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  pred_pc,
    output logic             pred_taken,
    output logic [1:0]       pred_comp,
    output logic [NCOMP-1:0] pred_comp_dir,
    input  logic             upd_valid,
    input  logic [PC_W-1:0]  upd_pc,
    input  logic             upd_taken,
    input  logic [NCOMP-1:0] upd_comp_dir
);

    localparam int WORD_W = imax(imax(BIM_IDX_W, SHORT_IDX_W),
                                 imax(LONG_IDX_W, SEL_IDX_W));

    logic [WORD_W-1:0] pred_word, upd_word;
    logic              pc_unused;

    assign pred_word = pred_pc[2 +: WORD_W];
    assign upd_word  = upd_pc[2 +: WORD_W];
    assign pc_unused = ^{pred_pc[1:0], pred_pc[PC_W-1:WORD_W+2],
                         upd_pc[1:0],  upd_pc[PC_W-1:WORD_W+2]};

    typedef struct packed {
        logic [LONG_HIST-1:0] ghr;
    } hist_st_t;

    hist_st_t st_d, st_q;
    logic [LONG_HIST-1:0] ghr_q;

    assign ghr_q = st_q.ghr;

    always_comb begin
        st_d = st_q;
        if (upd_valid) st_d.ghr = {st_q.ghr[LONG_HIST-2:0], upd_taken};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic [NCOMP-1:0] comp_dir;

    for (genvar g = 0; g < NCOMP; g++) begin : g_comp
        localparam int IW = (g == 0) ? BIM_IDX_W  :
                            (g == 1) ? SHORT_IDX_W : LONG_IDX_W;
        localparam int HW = (g == 0) ? 1          :
                            (g == 1) ? SHORT_HIST  : LONG_HIST;

        logic [HW-1:0] hist_g;

        if (g == 0) begin : g_nohist
            assign hist_g = '0;
        end else begin : g_hist
            assign hist_g = ghr_q[HW-1:0];
        end

        mhbp_pht #(
            .IDX_W  (IW),
            .HIST_W (HW)
        ) pht_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .hist     (hist_g),
            .rd_base  (pred_word[IW-1:0]),
            .rd_taken (comp_dir[g]),
            .wr_en    (upd_valid),
            .wr_base  (upd_word[IW-1:0]),
            .wr_taken (upd_taken)
        );
    end

    assign pred_comp_dir = comp_dir;

    mhbp_sel #(
        .IDX_W (SEL_IDX_W)
    ) sel_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_idx      (pred_word[SEL_IDX_W-1:0]),
        .comp_dir    (comp_dir),
        .pred_taken  (pred_taken),
        .pred_comp   (pred_comp),
        .wr_en       (upd_valid),
        .wr_idx      (upd_word[SEL_IDX_W-1:0]),
        .wr_taken    (upd_taken),
        .wr_comp_dir (upd_comp_dir)
    );

endmodule

// File: rtl/mhbp_chk.sv
module mhbp_chk #(
    parameter int GHR_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pred_taken,
    input logic [1:0]       pred_comp,
    input logic [2:0]       pred_comp_dir,
    input logic             upd_valid,
    input logic             upd_taken,
    input logic [GHR_W-1:0] ghr_q
);

    a_r8_comp_legal: assert property (@(posedge clk) disable iff (!rst_n)
        pred_comp != 2'd3);

    a_r8_final_follows_choice: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_comp != 2'd3) |-> (pred_taken == pred_comp_dir[pred_comp]));

    a_r5_history_shift: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (ghr_q == {$past(ghr_q[GHR_W-2:0]), $past(upd_taken)}));

    a_r9_history_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(ghr_q));

    a_r1_history_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (ghr_q == '0));

endmodule

bind mhbp_top mhbp_chk #(.GHR_W(LONG_HIST)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .pred_taken    (pred_taken),
    .pred_comp     (pred_comp),
    .pred_comp_dir (pred_comp_dir),
    .upd_valid     (upd_valid),
    .upd_taken     (upd_taken),
    .ghr_q         (ghr_q)
);

// File: tb/mhbp_tb.sv
module mhbp_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] pred_pc;
    logic        pred_taken;
    logic [1:0]  pred_comp;
    logic [2:0]  pred_comp_dir;
    logic        upd_valid;
    logic [31:0] upd_pc;
    logic        upd_taken;
    logic [2:0]  upd_comp_dir;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mhbp_top dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .pred_pc       (pred_pc),
        .pred_taken    (pred_taken),
        .pred_comp     (pred_comp),
        .pred_comp_dir (pred_comp_dir),
        .upd_valid     (upd_valid),
        .upd_pc        (upd_pc),
        .upd_taken     (upd_taken),
        .upd_comp_dir  (upd_comp_dir)
    );

    // reference state built from the requirements
    logic [1:0]  m_c0 [64];
    logic [1:0]  m_c1 [64];
    logic [1:0]  m_c2 [1024];
    logic [1:0]  m_sel [64][3];
    logic [11:0] m_ghr;

    function automatic int m_idx(int c, logic [31:0] pc);
        if (c == 0) return int'(pc[7:2]);
        if (c == 1) return int'(pc[7:2] ^ {2'b00, m_ghr[3:0]});
        return int'(pc[11:2] ^ m_ghr[9:0] ^ {8'b0, m_ghr[11:10]});
    endfunction

    function automatic logic m_dir(int c, logic [31:0] pc);
        if (c == 0) return m_c0[m_idx(0, pc)][1];
        if (c == 1) return m_c1[m_idx(1, pc)][1];
        return m_c2[m_idx(2, pc)][1];
    endfunction

    function automatic int m_choose(logic [31:0] pc);
        int s = int'(pc[7:2]);
        int b = 0;
        for (int c = 1; c < 3; c++) if (m_sel[s][c] >= m_sel[s][b]) b = c;
        return b;
    endfunction

    function automatic logic [1:0] bump(logic [1:0] v, bit up);
        if (up) return (v == 2'd3) ? v : v + 2'd1;
        return (v == 2'd0) ? v : v - 2'd1;
    endfunction

    task automatic m_reset();
        foreach (m_c0[i]) m_c0[i] = 2'd1;
        foreach (m_c1[i]) m_c1[i] = 2'd1;
        foreach (m_c2[i]) m_c2[i] = 2'd1;
        for (int i = 0; i < 64; i++) for (int c = 0; c < 3; c++) m_sel[i][c] = 2'd0;
        m_ghr = '0;
    endtask

    task automatic m_update(logic [31:0] pc, bit t, logic [2:0] dirs);
        int s = int'(pc[7:2]);
        bit hold = 1'b0;
        int i0 = m_idx(0, pc);
        int i1 = m_idx(1, pc);
        int i2 = m_idx(2, pc);
        for (int c = 0; c < 3; c++) if (dirs[c] == t && m_sel[s][c] == 2'd3) hold = 1'b1;
        for (int c = 0; c < 3; c++) begin
            if (dirs[c] == t) m_sel[s][c] = bump(m_sel[s][c], 1'b1);
            else if (!hold)   m_sel[s][c] = bump(m_sel[s][c], 1'b0);
        end
        m_c0[i0] = bump(m_c0[i0], t);
        m_c1[i1] = bump(m_c1[i1], t);
        m_c2[i2] = bump(m_c2[i2], t);
        m_ghr = {m_ghr[10:0], t};
    endtask

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // compare all prediction outputs for pc against the model (call mid-cycle)
    task automatic peek(logic [31:0] pc, string tag);
        logic [2:0] ed;
        int ec;
        pred_pc = pc;
        #1;
        ed = {m_dir(2, pc), m_dir(1, pc), m_dir(0, pc)};
        ec = m_choose(pc);
        chk({tag, " component guesses"}, int'(pred_comp_dir), int'(ed));
        chk({tag, " chosen component"}, int'(pred_comp), ec);
        chk({tag, " final direction"}, int'(pred_taken), int'(ed[ec]));
    endtask

    task automatic step(logic [31:0] pc, bit t, string tag);
        @(negedge clk);
        upd_valid = 1'b0;
        peek(pc, tag);
        upd_valid    = 1'b1;
        upd_pc       = pc;
        upd_taken    = t;
        upd_comp_dir = pred_comp_dir;
        @(posedge clk);
        m_update(pc, t, upd_comp_dir);
        #1 upd_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        peek(32'h0000_0040, "R1");
        peek(32'h0000_0a4c, "R1");
        chk("R1 direction after reset", int'(pred_taken), 0);
        chk("R1 chosen after reset", int'(pred_comp), 2);
    endtask

    task automatic t_bimodal();
        for (int i = 0; i < 5; i++) step(32'h0000_0040, 1'b1, "R2 saturate up");
        for (int i = 0; i < 4; i++) step(32'h0000_0040, 1'b0, "R2 saturate down");
        @(negedge clk);
        peek(32'h0000_0040, "R2 after bias run");
        chk("R2 bimodal bottom", int'(pred_comp_dir[0]), 0);
    endtask

    task automatic t_alternate();
        for (int i = 0; i < 48; i++) step(32'h0000_0a4c, i[0], "R3 R4 R5 alternating");
    endtask

    task automatic t_loop();
        for (int i = 0; i < 48; i++) step(32'h0000_1230, (i % 4) != 3, "R3 R4 R5 loop");
    endtask

    task automatic t_selector();
        for (int i = 0; i < 40; i++) begin
            step(32'h0000_0100, 1'b1, "R6 R7 R8 shared selector");
            step(32'h0000_0200, (i % 3) == 0, "R6 R7 R8 shared selector");
        end
    endtask

    task automatic t_idle();
        @(negedge clk);
        upd_valid    = 1'b0;
        upd_pc       = 32'h0000_0100;
        upd_taken    = 1'b0;
        upd_comp_dir = 3'b101;
        repeat (4) @(negedge clk);
        peek(32'h0000_0100, "R9 idle update");
        step(32'h0000_0100, 1'b1, "R9 after idle");
    endtask

    task automatic t_same_cycle();
        for (int i = 0; i < 3; i++) step(32'h0000_0300, 1'b1, "R9 same-cycle old value");
        @(negedge clk);
        peek(32'h0000_0300, "R9 next-edge new value");
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected <= %0d", cyc, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n        = 1'b0;
        pred_pc      = '0;
        upd_valid    = 1'b0;
        upd_pc       = '0;
        upd_taken    = 1'b0;
        upd_comp_dir = '0;
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bimodal();
        t_alternate();
        t_loop();
        t_selector();
        t_idle();
        t_same_cycle();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule